// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a 32-bit control register file that sits behind a simple memory-mapped port. It decodes a 4 KB window of word-aligned addresses. Every register except the protection key is guarded by that key. Software first writes a fixed unlock constant to offset 0x000, and until then all other writes are silently dropped. Reads are never gated.

Reset and clock-stop controls can only have bits set at their own address. Each one has a neighbouring alias one word above, and a write to the alias clears the bits that are set in the data. Two strap words can be overwritten only while a protect word two words above each is zero. Their clear aliases work whatever the protect word holds. Revision, identification and random-data words ignore writes. PLL extension words always report lock on bit 31. The random-data word returns a new pseudo-random value on each read. The strap words, the key and the second revision word take their reset values from input ports. The remaining reset values come from parameters.

Top module: `sysctl_keyreg`

## Requirements
- R1: In the first read after reset, offset 0x000 returns `key_init`, 0x500 returns `strap_a_init`, 0x510 returns `strap_b_init`, 0x014 returns `rev_init`, 0x004 returns `REV_FIXED`, 0x040/0x050/0x080/0x090 return their `*_INIT` parameters, 0x5B0/0x5B4 return `CHIP_ID0`/`CHIP_ID1`, and `bus_rdata` is 0 while reset is held.
- R2: A write to 0x000 stores 1 when the data equals `MAGIC` (default 32'h1688A8A8) and stores 0 for any other value. This write is accepted whether the block is locked or not.
- R3: While the key word reads 0, a write to any offset other than 0x000 changes no register.
- R4: When unlocked, a write to 0x040, 0x050, 0x080 or 0x090 stores the old value OR the data.
- R5: When unlocked, a write to 0x044, 0x054, 0x084 or 0x094 stores old AND NOT data into the word at that offset minus 4. Reads of these alias offsets return 0.
- R6: When unlocked, a write to 0x500 (or 0x510) replaces the strap word only if the word at 0x508 (or 0x518) is zero. Otherwise the strap is unchanged. The protect words at 0x508 and 0x518 are plain read/write.
- R7: When unlocked, a write to 0x504 (or 0x514) clears the data bits of the strap word at 0x500 (or 0x510), whatever the protect word holds.
- R8: Writes to 0x004, 0x014, 0x5B0, 0x5B4 and 0x540 are dropped.
- R9: 0x200, 0x220 and 0x240 (PLL parameters) and 0x204, 0x224 and 0x244 (PLL extensions) are plain read/write when unlocked. A read of an extension word returns the stored value with bit 31 forced to 1.
- R10: Reads of 0x540 return a 32-bit Galois LFSR state. The first read after reset returns `LFSR_SEED`, and each later read returns next = (s >> 1) XOR (s[0] ? `LFSR_POLY` : 0) with default poly 32'h80200003. The state advances only on a read of 0x540, and the read works whether the block is locked or not.
- R11: An address at or above 0x1000, an address whose two low bits are nonzero, or an in-window offset with no register reads 0, and a write to it changes nothing.
- R12: Read data appears on `bus_rdata` on the clock edge that accepts the read. It keeps its value through writes and idle cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 32 | Write data |
| key_init | input | 32 | Reset value of the key word |
| strap_a_init | input | 32 | Reset value of the first strap word |
| strap_b_init | input | 32 | Reset value of the second strap word |
| rev_init | input | 32 | Reset value of the second revision word |
| bus_rdata | output | 32 | Registered read data |

## Verification
On every cycle the assertions check four things. A locked write leaves the control, strap, protect and PLL words untouched. The set address of a reset-control word never drops a bit. A strap word holds while its protect word is nonzero. The random state and `bus_rdata` move only on the reads that should move them. Only the directed scenarios can show the rest: the exact key compare, the clear aliases hitting the word below, the forced lock bit, the LFSR sequence values, and out-of-window, misaligned and unmapped addresses not aliasing onto real registers.

// File: rtl/sysctl_pkg.sv
// Shared slot numbering, access kinds and window offsets for the
// key-locked register file. Slot order matters: each clear alias sits at
// slot+1 of the word it clears, and each strap protect word at slot+2.
package sysctl_pkg;

    localparam int NSLOT  = 27;
    localparam int SLOT_W = 5;
    localparam int S_NONE = 31;

    localparam int S_KEY   = 0;
    localparam int S_REV0  = 1;
    localparam int S_REV1  = 2;
    localparam int S_RST0  = 3;
    localparam int S_RST0C = 4;
    localparam int S_RST1  = 5;
    localparam int S_RST1C = 6;
    localparam int S_CLK0  = 7;
    localparam int S_CLK0C = 8;
    localparam int S_CLK1  = 9;
    localparam int S_CLK1C = 10;
    localparam int S_PLLA  = 11;
    localparam int S_PLLAX = 12;
    localparam int S_PLLB  = 13;
    localparam int S_PLLBX = 14;
    localparam int S_PLLC  = 15;
    localparam int S_PLLCX = 16;
    localparam int S_STRA  = 17;
    localparam int S_STRAC = 18;
    localparam int S_PROTA = 19;
    localparam int S_STRB  = 20;
    localparam int S_STRBC = 21;
    localparam int S_PROTB = 22;
    localparam int S_RNGC  = 23;
    localparam int S_RNGD  = 24;
    localparam int S_ID0   = 25;
    localparam int S_ID1   = 26;

    typedef enum logic [2:0] {
        K_KEY, K_RO, K_W1S, K_CLR, K_PLAIN, K_PLLX, K_STRAP, K_RNG
    } kind_t;

    // Access behaviour of a slot.
    function automatic kind_t slot_kind(input int s);
        case (s)
            S_KEY:                              return K_KEY;
            S_RST0, S_RST1, S_CLK0, S_CLK1:     return K_W1S;
            S_RST0C, S_RST1C, S_CLK0C, S_CLK1C,
            S_STRAC, S_STRBC:                   return K_CLR;
            S_PLLAX, S_PLLBX, S_PLLCX:          return K_PLLX;
            S_PLLA, S_PLLB, S_PLLC,
            S_PROTA, S_PROTB, S_RNGC:           return K_PLAIN;
            S_STRA, S_STRB:                     return K_STRAP;
            S_RNGD:                             return K_RNG;
            default:                            return K_RO;
        endcase
    endfunction

    // Byte offset of a slot inside the window.
    function automatic logic [11:0] slot_offset(input int s);
        case (s)
            S_KEY:   return 12'h000;
            S_REV0:  return 12'h004;
            S_REV1:  return 12'h014;
            S_RST0:  return 12'h040;
            S_RST0C: return 12'h044;
            S_RST1:  return 12'h050;
            S_RST1C: return 12'h054;
            S_CLK0:  return 12'h080;
            S_CLK0C: return 12'h084;
            S_CLK1:  return 12'h090;
            S_CLK1C: return 12'h094;
            S_PLLA:  return 12'h200;
            S_PLLAX: return 12'h204;
            S_PLLB:  return 12'h220;
            S_PLLBX: return 12'h224;
            S_PLLC:  return 12'h240;
            S_PLLCX: return 12'h244;
            S_STRA:  return 12'h500;
            S_STRAC: return 12'h504;
            S_PROTA: return 12'h508;
            S_STRB:  return 12'h510;
            S_STRBC: return 12'h514;
            S_PROTB: return 12'h518;
            S_RNGC:  return 12'h524;
            S_RNGD:  return 12'h540;
            S_ID0:   return 12'h5B0;
            default: return 12'h5B4;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: maps a byte address onto a slot number.
// Assumes a window of WINDOW_BYTES (a power of two below 2**ADDR_W).
// Misaligned, out-of-window and unmapped addresses give S_NONE.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int WINDOW_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot
);
    localparam int OFF_W = $clog2(WINDOW_BYTES);

    logic in_win;

    // Window and alignment qualification.
    always_comb in_win = (addr < ADDR_W'(WINDOW_BYTES)) && (addr[1:0] == 2'b00);

    // Compare the offset against every slot; at most one can match.
    always_comb begin
        slot = SLOT_W'(S_NONE);
        for (int s = 0; s < NSLOT; s++) begin
            if (in_win && addr[OFF_W-1:0] == OFF_W'(slot_offset(s)))
                slot = SLOT_W'(s);
        end
    end
endmodule

// File: rtl/sysctl_lfsr.sv
// Galois LFSR random source. Advances one step when step is high.
// Assumes SEED is nonzero so the sequence never locks at zero.
module sysctl_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] SEED  = 32'hACE1_2468,
    parameter logic [31:0] POLY  = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] state_q
);
    // Shift right and fold the polynomial in when a one drops out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= WIDTH'(SEED);
        else if (step)
            state_q <= {1'b0, state_q[WIDTH-1:1]} ^ (state_q[0] ? WIDTH'(POLY) : '0);
    end
endmodule

// File: rtl/sysctl_regs.sv
// Register storage with per-slot write rules. Each slot gets its own flop
// built according to its kind. Writes other than to the key slot need the
// key word to be nonzero. Assumes the slot ordering given in sysctl_pkg.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] MAGIC = 32'h1688_A8A8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           slot,
    input  logic [31:0]                 wdata,
    input  logic [NSLOT-1:0][31:0]      init_val,
    output logic [NSLOT-1:0][31:0]      word_q
);
    logic unlocked;

    // Any nonzero key value opens the write gate.
    always_comb unlocked = (word_q[S_KEY] != 32'd0);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [31:0] q;
        assign word_q[i] = q;

        if (slot_kind(i) == K_KEY) begin : g_key
            // Key compare: store a flag, never the written data.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= init_val[i];
                else if (wr_en && slot == SLOT_W'(i))
                    q <= (wdata == MAGIC) ? 32'd1 : 32'd0;
            end
        end else if (slot_kind(i) == K_W1S) begin : g_w1s
            // Set at own address, clear through the alias one slot up.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= init_val[i];
                else if (wr_en && unlocked) begin
                    if (slot == SLOT_W'(i))
                        q <= q | wdata;
                    else if (slot == SLOT_W'(i + 1))
                        q <= q & ~wdata;
                end
            end
        end else if (slot_kind(i) == K_STRAP) begin : g_strap
            // Overwrite only while the protect word two slots up is zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= init_val[i];
                else if (wr_en && unlocked) begin
                    if (slot == SLOT_W'(i) && word_q[i + 2] == 32'd0)
                        q <= wdata;
                    else if (slot == SLOT_W'(i + 1))
                        q <= q & ~wdata;
                end
            end
        end else if (slot_kind(i) == K_PLAIN || slot_kind(i) == K_PLLX) begin : g_plain
            // Ordinary read/write word behind the key.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= init_val[i];
                else if (wr_en && unlocked && slot == SLOT_W'(i))
                    q <= wdata;
            end
        end else begin : g_const
            // Read-only, alias and random slots: load at reset, then hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= init_val[i];
            end
        end
    end
endmodule

// File: rtl/sysctl_keyreg.sv
// Top of the key-locked control register file. It decodes the bus address,
// applies writes through sysctl_regs and returns read data one edge later.
// Read data is held between reads. Assumes one access per cycle and
// word-sized accesses only.
module sysctl_keyreg
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          WINDOW    = 4096,
    parameter logic [31:0] MAGIC     = 32'h1688_A8A8,
    parameter logic [31:0] REV_FIXED = 32'h0503_0303,
    parameter logic [31:0] CHIP_ID0  = 32'h5A5A_0001,
    parameter logic [31:0] CHIP_ID1  = 32'hC3C3_0002,
    parameter logic [31:0] RST0_INIT = 32'hF7C3_FED8,
    parameter logic [31:0] RST1_INIT = 32'h0DFF_FFFC,
    parameter logic [31:0] CLK0_INIT = 32'hFFFF_7F8A,
    parameter logic [31:0] CLK1_INIT = 32'hFFF0_FFF0,
    parameter logic [31:0] PLLA_INIT = 32'h1000_408F,
    parameter logic [31:0] PLLB_INIT = 32'h1008_405F,
    parameter logic [31:0] PLLC_INIT = 32'h1004_077F,
    parameter logic [31:0] LFSR_SEED = 32'hACE1_2468,
    parameter logic [31:0] LFSR_POLY = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       key_init,
    input  logic [31:0]       strap_a_init,
    input  logic [31:0]       strap_b_init,
    input  logic [31:0]       rev_init,
    output logic [31:0]       bus_rdata
);
    logic [SLOT_W-1:0]      slot;
    logic [NSLOT-1:0][31:0] init_val;
    logic [NSLOT-1:0][31:0] word_q;
    logic [31:0]            lfsr_q;
    logic [31:0]            rd_val;
    logic                   rd_en;
    logic                   rng_step;

    sysctl_decode #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW)) i_decode (
        .addr (bus_addr),
        .slot (slot)
    );

    // Reset image: port-driven words plus parameter constants.
    always_comb begin
        init_val          = '0;
        init_val[S_KEY]   = key_init;
        init_val[S_REV0]  = REV_FIXED;
        init_val[S_REV1]  = rev_init;
        init_val[S_RST0]  = RST0_INIT;
        init_val[S_RST1]  = RST1_INIT;
        init_val[S_CLK0]  = CLK0_INIT;
        init_val[S_CLK1]  = CLK1_INIT;
        init_val[S_PLLA]  = PLLA_INIT;
        init_val[S_PLLB]  = PLLB_INIT;
        init_val[S_PLLC]  = PLLC_INIT;
        init_val[S_STRA]  = strap_a_init;
        init_val[S_STRB]  = strap_b_init;
        init_val[S_ID0]   = CHIP_ID0;
        init_val[S_ID1]   = CHIP_ID1;
    end

    sysctl_regs #(.MAGIC(MAGIC)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_valid && bus_write),
        .slot     (slot),
        .wdata    (bus_wdata),
        .init_val (init_val),
        .word_q   (word_q)
    );

    // Read strobes for the response register and the random source.
    always_comb rd_en    = bus_valid && !bus_write;
    always_comb rng_step = rd_en && (slot == SLOT_W'(S_RNGD));

    sysctl_lfsr #(.WIDTH(32), .SEED(LFSR_SEED), .POLY(LFSR_POLY)) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (rng_step),
        .state_q (lfsr_q)
    );

    // Read mux: stored word, with lock bit and random overrides.
    always_comb begin
        rd_val = '0;
        if (slot != SLOT_W'(S_NONE)) begin
            rd_val = word_q[slot];
            case (slot_kind(int'(slot)))
                K_PLLX:  rd_val[31] = 1'b1;
                K_RNG:   rd_val     = lfsr_q;
                default: ;
            endcase
        end
    end

    // Response register: loads on reads only, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/sysctl_keyreg_chk.sv
// Cycle-level checker for sysctl_keyreg, attached with bind below.
// It watches the bus, a few stored words and the random state.
module sysctl_keyreg_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       key_q,
    input logic [31:0]       rst0_q,
    input logic [31:0]       strap_a_q,
    input logic [31:0]       prot_a_q,
    input logic [31:0]       pll_a_q,
    input logic [31:0]       lfsr_q
);
    localparam logic [ADDR_W-1:0] A_RST0 = ADDR_W'(12'h040);
    localparam logic [ADDR_W-1:0] A_STRA = ADDR_W'(12'h500);
    localparam logic [ADDR_W-1:0] A_RNGD = ADDR_W'(12'h540);

    // R3: a locked write leaves the guarded words untouched
    a_r3_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q == 32'd0 && bus_valid && bus_write && bus_addr != '0)
        |=> ($stable(rst0_q) && $stable(strap_a_q) && $stable(prot_a_q) && $stable(pll_a_q)));

    // R4: the set address never drops a bit
    a_r4_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q != 32'd0 && bus_valid && bus_write && bus_addr == A_RST0)
        |=> ((rst0_q & $past(rst0_q)) == $past(rst0_q)));

    // R6: strap holds while its protect word is nonzero
    a_r6_strap_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_STRA && prot_a_q != 32'd0)
        |=> $stable(strap_a_q));

    // R10: random state moves only on a read of the random word
    a_r10_rng_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write && bus_addr == A_RNGD) |=> $stable(lfsr_q));

    // R12: read data holds when no read is accepted
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .key_q     (word_q[sysctl_pkg::S_KEY]),
    .rst0_q    (word_q[sysctl_pkg::S_RST0]),
    .strap_a_q (word_q[sysctl_pkg::S_STRA]),
    .prot_a_q  (word_q[sysctl_pkg::S_PROTA]),
    .pll_a_q   (word_q[sysctl_pkg::S_PLLA]),
    .lfsr_q    (lfsr_q)
);

// File: tb/test_sysctl_keyreg.sv
`timescale 1ns/1ps
module test_sysctl_keyreg;
    localparam logic [31:0] MAGIC     = 32'h1688_A8A8;
    localparam logic [31:0] REV_FIXED = 32'h0503_0303;
    localparam logic [31:0] CHIP_ID0  = 32'h5A5A_0001;
    localparam logic [31:0] CHIP_ID1  = 32'hC3C3_0002;
    localparam logic [31:0] RST0_INIT = 32'hF7C3_FED8;
    localparam logic [31:0] RST1_INIT = 32'h0DFF_FFFC;
    localparam logic [31:0] CLK0_INIT = 32'hFFFF_7F8A;
    localparam logic [31:0] CLK1_INIT = 32'hFFF0_FFF0;
    localparam logic [31:0] PLLA_INIT = 32'h1000_408F;
    localparam logic [31:0] SEED      = 32'hACE1_2468;
    localparam logic [31:0] POLY      = 32'h8020_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] key_init = 32'd0;
    logic [31:0] strap_a_init = 32'h0000_30C3;
    logic [31:0] strap_b_init = 32'h1234_0F0F;
    logic [31:0] rev_init = 32'h0503_0403;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] rng_model = SEED;

    always #4 clk = ~clk;

    sysctl_keyreg i_sysctl_keyreg (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .key_init(key_init),
        .strap_a_init(strap_a_init), .strap_b_init(strap_b_init),
        .rev_init(rev_init), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] rng_next(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? POLY : 32'd0);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata in reset", bus_rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rd(16'h000, d); check("R1 key", d, 32'd0);
        rd(16'h500, d); check("R1 strap a", d, 32'h0000_30C3);
        rd(16'h510, d); check("R1 strap b", d, 32'h1234_0F0F);
        rd(16'h014, d); check("R1 rev port", d, 32'h0503_0403);
        rd(16'h004, d); check("R1 rev fixed", d, REV_FIXED);
        rd(16'h040, d); check("R1 rst0", d, RST0_INIT);
        rd(16'h050, d); check("R1 rst1", d, RST1_INIT);
        rd(16'h080, d); check("R1 clk0", d, CLK0_INIT);
        rd(16'h5B0, d); check("R1 id0", d, CHIP_ID0);
    endtask

    task automatic t_locked();
        logic [31:0] d;
        wr(16'h040, 32'hFFFF_FFFF);
        wr(16'h084, 32'hFFFF_FFFF);
        wr(16'h500, 32'h0BAD_0BAD);
        wr(16'h200, 32'h0000_0001);
        rd(16'h040, d); check("R3 locked set", d, RST0_INIT);
        rd(16'h080, d); check("R3 locked clear", d, CLK0_INIT);
        rd(16'h500, d); check("R3 locked strap", d, 32'h0000_30C3);
        rd(16'h200, d); check("R3 locked pll", d, PLLA_INIT);
    endtask

    task automatic t_key();
        logic [31:0] d;
        wr(16'h000, 32'h1688_A8A9);
        rd(16'h000, d); check("R2 wrong key", d, 32'd0);
        wr(16'h000, MAGIC);
        rd(16'h000, d); check("R2 magic key", d, 32'd1);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        logic [31:0] e;
        wr(16'h040, 32'h0800_0127);
        e = RST0_INIT | 32'h0800_0127;
        rd(16'h040, d); check("R4 rst0 set", d, e);
        wr(16'h044, 32'hF000_0003);
        e = e & ~32'hF000_0003;
        rd(16'h040, d); check("R5 rst0 clear", d, e);
        rd(16'h044, d); check("R5 alias reads 0", d, 32'd0);
        wr(16'h090, 32'h000F_0000);
        rd(16'h090, d); check("R4 clk1 set", d, 32'hFFFF_FFF0);
        wr(16'h094, 32'hFF00_00F0);
        rd(16'h090, d); check("R5 clk1 clear", d, 32'h00FF_FF00);
        rd(16'h050, d); check("R5 rst1 untouched", d, RST1_INIT);
    endtask

    task automatic t_pll();
        logic [31:0] d;
        wr(16'h204, 32'h0000_1234);
        rd(16'h204, d); check("R9 ext lock bit", d, 32'h8000_1234);
        wr(16'h244, 32'h8000_0001);
        rd(16'h244, d); check("R9 ext lock bit set", d, 32'h8000_0001);
        rd(16'h224, d); check("R9 ext reset lock", d, 32'h8000_0000);
        wr(16'h200, 32'h0000_00FF);
        rd(16'h200, d); check("R9 pll plain", d, 32'h0000_00FF);
    endtask

    task automatic t_strap();
        logic [31:0] d;
        wr(16'h500, 32'hAAAA_5555);
        rd(16'h500, d); check("R6 strap open", d, 32'hAAAA_5555);
        wr(16'h508, 32'h0000_0001);
        rd(16'h508, d); check("R6 protect rw", d, 32'h0000_0001);
        wr(16'h500, 32'h1111_1111);
        rd(16'h500, d); check("R6 strap guarded", d, 32'hAAAA_5555);
        wr(16'h504, 32'h0000_0005);
        rd(16'h500, d); check("R7 clear under protect", d, 32'hAAAA_5550);
        wr(16'h518, 32'h0000_0000);
        wr(16'h510, 32'hCAFE_0000);
        rd(16'h510, d); check("R6 strap b open", d, 32'hCAFE_0000);
        wr(16'h514, 32'h0A00_0000);
        rd(16'h510, d); check("R7 strap b clear", d, 32'hC0FE_0000);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(16'h004, 32'h0);
        wr(16'h014, 32'hFFFF_FFFF);
        wr(16'h5B0, 32'h0);
        wr(16'h5B4, 32'h0);
        wr(16'h540, 32'h0);
        rd(16'h004, d); check("R8 rev fixed ro", d, REV_FIXED);
        rd(16'h014, d); check("R8 rev port ro", d, 32'h0503_0403);
        rd(16'h5B0, d); check("R8 id0 ro", d, CHIP_ID0);
        rd(16'h5B4, d); check("R8 id1 ro", d, CHIP_ID1);
    endtask

    task automatic t_rng();
        logic [31:0] d;
        rd(16'h540, d); check("R10 first value", d, rng_model);
        rng_model = rng_next(rng_model);
        rd(16'h540, d); check("R10 second value", d, rng_model);
        rng_model = rng_next(rng_model);
        rd(16'h524, d);
        wr(16'h540, 32'h1234_5678);
        rd(16'h540, d); check("R10 no step on other access", d, rng_model);
        rng_model = rng_next(rng_model);
        wr(16'h000, 32'd0);
        rd(16'h540, d); check("R10 read while locked", d, rng_model);
        rng_model = rng_next(rng_model);
        wr(16'h000, MAGIC);
    endtask

    task automatic t_range();
        logic [31:0] d;
        logic [31:0] e;
        rd(16'h040, e);
        wr(16'h1040, 32'hFFFF_FFFF);
        wr(16'h0041, 32'hFFFF_FFFF);
        wr(16'h0044 + 16'h1000, 32'hFFFF_FFFF);
        rd(16'h040, d); check("R11 no alias write", d, e);
        rd(16'h1040, d); check("R11 out of window read", d, 32'd0);
        rd(16'h0042, d); check("R11 misaligned read", d, 32'd0);
        wr(16'h0300, 32'h5555_5555);
        rd(16'h0300, d); check("R11 unmapped read", d, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        rd(16'h5B4, d);
        wr(16'h508, 32'h0);
        repeat (3) @(negedge clk);
        check("R12 rdata held", bus_rdata, CHIP_ID1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 16'h5B0;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R12 next-edge data", bus_rdata, CHIP_ID0);
    endtask

    task automatic t_relock();
        logic [31:0] d;
        wr(16'h000, 32'h0000_0001);
        rd(16'h000, d); check("R2 relock", d, 32'd0);
        wr(16'h508, 32'h0000_0007);
        rd(16'h508, d); check("R3 relocked protect", d, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_locked();
        t_key();
        t_setclr();
        t_pll();
        t_strap();
        t_readonly();
        t_rng();
        t_range();
        t_hold();
        t_relock();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule